// File: doc/BRIEF.md
# Multi-rate auto-refresh sequencer

This block sits inside a DRAM device and turns each auto-refresh command from the memory controller into a run of one to four refresh slots. The controller sends bare refresh pulses at a fixed rate. It never supplies an address. The block keeps its own refresh group counter and refreshes one group per command.

While the normal slot runs, the block checks a weak-group table at three phase-shifted positions: a quarter, a half and three quarters of the group space ahead of the current group. Weak rows must be refreshed four times as often as the rest. For each shifted group whose weak bit is set, the block appends one extra slot after the normal slot.

A sideband busy line stays high across the whole extended refresh, so the controller sees a refresh time that grows with the number of extra slots. A group output and an extra-slot flag show which group each slot refreshes. A refresh command that arrives while the block is busy is dropped and flagged.

Top module: `multirate_refresh_seq`

## Requirements
- R1: After reset, busy, error and extra-slot flag are low and the group output is 0; the first accepted command refreshes group 0.
- R2: A command sampled while idle refreshes the group held in the internal counter, and the counter then advances by one modulo NUM_GROUPS, wrapping from NUM_GROUPS-1 to 0.
- R3: Busy goes high in the cycle after the clock edge that samples an idle command, and every slot (normal or extra) lasts exactly TRFC_CYC cycles.
- R4: For current group g, the candidates are (g+N/4), (g+N/2) and (g+3N/4) modulo N. Each candidate whose weak bit is 1 adds exactly one extra slot. The weak bit of g itself adds none.
- R5: Extra slots follow the normal slot back to back, in the order +N/4, +N/2, +3N/4. During an extra slot the group output shows the shifted group and the extra flag is 1. During the normal slot the flag is 0.
- R6: Busy stays high without a gap from the first cycle of the normal slot to the last cycle of the last extra slot, for TRFC_CYC*(1+k) cycles in total, k being the number of weak candidates; it never exceeds 4*TRFC_CYC cycles.
- R7: A command sampled while busy raises the error output for exactly one cycle, in the cycle after that edge. It changes neither the running slot sequence nor the group counter and is not queued.
- R8: A table write (write enable high, address, data bit) sets the weak bit of that group to the data bit. Every command issued after the write uses the new value.
- R9: The extra flag is high only while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_cmd_i | input | 1 | Auto-refresh command pulse from the controller |
| tbl_we_i | input | 1 | Weak-group table write enable |
| tbl_addr_i | input | $clog2(NUM_GROUPS) | Group whose weak bit is written |
| tbl_wdata_i | input | 1 | Weak bit value to write |
| ref_busy_o | output | 1 | Sideband busy, high for the whole extended refresh |
| ref_group_o | output | $clog2(NUM_GROUPS) | Group refreshed by the current slot |
| ref_extra_o | output | 1 | 1 during an appended slot, 0 during the normal slot |
| ref_err_o | output | 1 | One-cycle pulse when a command arrives while busy |

## Verification
The bench builds the block with NUM_GROUPS = 16 and TRFC_CYC = 5, so the quarter step is 4. With these values a sweep of sixteen commands covers the counter wrap, and the shifted candidates also wrap past group 15. A slot of five cycles leaves one spare cycle between the end of the three-step lookup and the end of the normal slot, so the lookup is tested close to its deadline. The bench keeps its own copy of the weak table and derives the expected slot order, slot groups and busy length for every command, including zero, one, two and three extra slots and a command dropped mid-refresh.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_SLOT = 1'b1
    } seq_state_e;

    localparam int unsigned PHASE_CNT = 3;

    // Lowest set bit of a candidate mask; phase 0 (+N/4) has priority.
    function automatic logic [1:0] first_phase(input logic [PHASE_CNT-1:0] m);
        logic [1:0] r;
        if (m[0])      r = 2'd0;
        else if (m[1]) r = 2'd1;
        else           r = 2'd2;
        return r;
    endfunction

endpackage

// File: rtl/refseq_weak_table.sv
module refseq_weak_table #(
    parameter int unsigned NUM_GROUPS = 1024,
    localparam int unsigned GW = $clog2(NUM_GROUPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [GW-1:0] wr_addr_i,
    input  logic          wr_bit_i,
    input  logic [GW-1:0] rd_addr_i,
    output logic          rd_bit_o
);

    logic [NUM_GROUPS-1:0] bits_d, bits_q;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bit
        always_comb begin
            bits_d[g] = bits_q[g];
            if (wr_en_i && (wr_addr_i == GW'(g))) begin
                bits_d[g] = wr_bit_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

    assign rd_bit_o = bits_q[rd_addr_i];

endmodule

// File: rtl/refseq_phase_lookup.sv
module refseq_phase_lookup #(
    parameter int unsigned NUM_GROUPS = 1024,
    localparam int unsigned GW = $clog2(NUM_GROUPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [GW-1:0] base_i,
    output logic [GW-1:0] rd_addr_o,
    input  logic          rd_bit_i,
    output logic [2:0]    mask_o
);

    localparam logic [GW-1:0] OFS_Q1 = GW'(NUM_GROUPS / 4);
    localparam logic [GW-1:0] OFS_Q2 = GW'(NUM_GROUPS / 2);
    localparam logic [GW-1:0] OFS_Q3 = GW'((3 * NUM_GROUPS) / 4);

    typedef struct packed {
        logic          active;
        logic [1:0]    step;
        logic [GW-1:0] base;
        logic [2:0]    mask;
    } lk_state_t;

    lk_state_t lk_d, lk_q;
    logic [GW-1:0] step_ofs;

    always_comb begin
        case (lk_q.step)
            2'd0:    step_ofs = OFS_Q1;
            2'd1:    step_ofs = OFS_Q2;
            default: step_ofs = OFS_Q3;
        endcase
        rd_addr_o = lk_q.base + step_ofs;

        lk_d = lk_q;
        if (start_i) begin
            lk_d.active = 1'b1;
            lk_d.step   = 2'd0;
            lk_d.base   = base_i;
            lk_d.mask   = 3'b000;
        end else if (lk_q.active) begin
            lk_d.mask[lk_q.step] = rd_bit_i;
            if (lk_q.step == 2'd2) begin
                lk_d.active = 1'b0;
            end else begin
                lk_d.step = lk_q.step + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign mask_o = lk_q.mask;

endmodule

// File: rtl/refseq_slot_ctrl.sv
module refseq_slot_ctrl
    import refseq_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 1024,
    parameter int unsigned TRFC_CYC   = 23,
    localparam int unsigned GW = $clog2(NUM_GROUPS),
    localparam int unsigned CW = $clog2(TRFC_CYC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_cmd_i,
    input  logic [2:0]    lk_mask_i,
    output logic          lk_start_o,
    output logic [GW-1:0] lk_base_o,
    output logic          busy_o,
    output logic [GW-1:0] group_o,
    output logic          extra_o,
    output logic          err_o
);

    localparam logic [CW-1:0] CNT_LOAD = CW'(TRFC_CYC - 1);
    localparam logic [GW-1:0] OFS_Q1 = GW'(NUM_GROUPS / 4);
    localparam logic [GW-1:0] OFS_Q2 = GW'(NUM_GROUPS / 2);
    localparam logic [GW-1:0] OFS_Q3 = GW'((3 * NUM_GROUPS) / 4);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
        logic [GW-1:0] ctr;
        logic [GW-1:0] grp;
        logic [GW-1:0] base;
        logic [2:0]    pend;
        logic          extra;
        logic          err;
    } sc_state_t;

    sc_state_t sc_d, sc_q;
    logic [2:0]    mask_now;
    logic [1:0]    pick;
    logic [GW-1:0] pick_ofs;

    always_comb begin
        sc_d       = sc_q;
        sc_d.err   = 1'b0;
        lk_start_o = 1'b0;
        mask_now   = 3'b000;
        pick       = 2'd0;
        pick_ofs   = OFS_Q1;

        if (ref_cmd_i && (sc_q.st == SEQ_SLOT)) begin
            sc_d.err = 1'b1;
        end

        case (sc_q.st)
            SEQ_IDLE: begin
                if (ref_cmd_i) begin
                    sc_d.st    = SEQ_SLOT;
                    sc_d.cnt   = CNT_LOAD;
                    sc_d.grp   = sc_q.ctr;
                    sc_d.base  = sc_q.ctr;
                    sc_d.ctr   = sc_q.ctr + 1'b1;
                    sc_d.extra = 1'b0;
                    sc_d.pend  = 3'b000;
                    lk_start_o = 1'b1;
                end
            end
            SEQ_SLOT: begin
                if (sc_q.cnt == '0) begin
                    mask_now = sc_q.extra ? sc_q.pend : lk_mask_i;
                    if (mask_now != 3'b000) begin
                        pick = first_phase(mask_now);
                        case (pick)
                            2'd0:    pick_ofs = OFS_Q1;
                            2'd1:    pick_ofs = OFS_Q2;
                            default: pick_ofs = OFS_Q3;
                        endcase
                        sc_d.grp   = sc_q.base + pick_ofs;
                        sc_d.pend  = mask_now & ~(3'b001 << pick);
                        sc_d.extra = 1'b1;
                        sc_d.cnt   = CNT_LOAD;
                    end else begin
                        sc_d.st    = SEQ_IDLE;
                        sc_d.extra = 1'b0;
                        sc_d.pend  = 3'b000;
                    end
                end else begin
                    sc_d.cnt = sc_q.cnt - 1'b1;
                end
            end
            default: sc_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_q <= '0;
        end else begin
            sc_q <= sc_d;
        end
    end

    assign lk_base_o = sc_q.ctr;
    assign busy_o    = (sc_q.st == SEQ_SLOT);
    assign group_o   = sc_q.grp;
    assign extra_o   = sc_q.extra;
    assign err_o     = sc_q.err;

endmodule

// File: rtl/multirate_refresh_seq.sv
module multirate_refresh_seq #(
    parameter int unsigned NUM_GROUPS = 1024,
    parameter int unsigned TRFC_CYC   = 23,
    localparam int unsigned GW = $clog2(NUM_GROUPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_cmd_i,
    input  logic          tbl_we_i,
    input  logic [GW-1:0] tbl_addr_i,
    input  logic          tbl_wdata_i,
    output logic          ref_busy_o,
    output logic [GW-1:0] ref_group_o,
    output logic          ref_extra_o,
    output logic          ref_err_o
);

    logic          lk_start;
    logic [GW-1:0] lk_base;
    logic [GW-1:0] lk_rd_addr;
    logic          lk_rd_bit;
    logic [2:0]    lk_mask;

    refseq_weak_table #(.NUM_GROUPS(NUM_GROUPS)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (tbl_we_i),
        .wr_addr_i (tbl_addr_i),
        .wr_bit_i  (tbl_wdata_i),
        .rd_addr_i (lk_rd_addr),
        .rd_bit_o  (lk_rd_bit)
    );

    refseq_phase_lookup #(.NUM_GROUPS(NUM_GROUPS)) u_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (lk_start),
        .base_i    (lk_base),
        .rd_addr_o (lk_rd_addr),
        .rd_bit_i  (lk_rd_bit),
        .mask_o    (lk_mask)
    );

    refseq_slot_ctrl #(.NUM_GROUPS(NUM_GROUPS), .TRFC_CYC(TRFC_CYC)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_cmd_i  (ref_cmd_i),
        .lk_mask_i  (lk_mask),
        .lk_start_o (lk_start),
        .lk_base_o  (lk_base),
        .busy_o     (ref_busy_o),
        .group_o    (ref_group_o),
        .extra_o    (ref_extra_o),
        .err_o      (ref_err_o)
    );

endmodule

// File: rtl/refseq_chk.sv
module refseq_chk #(
    parameter int unsigned NUM_GROUPS = 1024,
    parameter int unsigned TRFC_CYC   = 23,
    localparam int unsigned GW = $clog2(NUM_GROUPS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ref_cmd,
    input logic          busy,
    input logic [GW-1:0] grp,
    input logic          extra,
    input logic          err
);

    localparam int unsigned MAX_RUN = 4 * TRFC_CYC;

    int unsigned   run_q;
    logic          seen_q;
    logic [GW-1:0] last_norm_q;
    logic [GW-1:0] next_norm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q       <= 0;
            seen_q      <= 1'b0;
            last_norm_q <= '0;
        end else begin
            run_q <= busy ? run_q + 1 : 0;
            if (busy && run_q == 0) begin
                seen_q      <= 1'b1;
                last_norm_q <= grp;
            end
        end
    end

    assign next_norm = last_norm_q + 1'b1;

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ref_cmd));

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(ref_cmd && busy));

    // R9
    extra_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        extra |-> busy);

    // R5
    normal_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !extra);

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < MAX_RUN));

    // R2
    group_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && seen_q) |-> (grp == next_norm));

    // R1
    first_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !seen_q) |-> (grp == '0));

endmodule

bind multirate_refresh_seq refseq_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .TRFC_CYC   (TRFC_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_cmd (ref_cmd_i),
    .busy    (ref_busy_o),
    .grp     (ref_group_o),
    .extra   (ref_extra_o),
    .err     (ref_err_o)
);

// File: tb/multirate_refresh_seq_test.sv
`timescale 1ns/1ps
module multirate_refresh_seq_test;

    localparam int N    = 16;
    localparam int TRFC = 5;
    localparam int GW   = $clog2(N);
    localparam int Q    = N / 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_cmd = 1'b0;
    logic          tbl_we = 1'b0;
    logic [GW-1:0] tbl_addr = '0;
    logic          tbl_wdata = 1'b0;
    logic          busy;
    logic [GW-1:0] grp;
    logic          extra;
    logic          err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    bit weak_sh [N];
    int expg   = 0;

    always #4 clk = ~clk;

    multirate_refresh_seq #(.NUM_GROUPS(N), .TRFC_CYC(TRFC)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_cmd_i   (ref_cmd),
        .tbl_we_i    (tbl_we),
        .tbl_addr_i  (tbl_addr),
        .tbl_wdata_i (tbl_wdata),
        .ref_busy_o  (busy),
        .ref_group_o (grp),
        .ref_extra_o (extra),
        .ref_err_o   (err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic wr_weak(input int a, input bit v);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = GW'(a); tbl_wdata = v;
        @(negedge clk);
        tbl_we = 1'b0;
        weak_sh[a] = v;
    endtask

    // Issue one command, follow the whole refresh, compare with shadow model.
    task automatic run_ref(input string tag);
        int exp_grp [4];
        int got_grp [4];
        int got_ext [4];
        int nslot = 1;
        int n = 0;
        exp_grp[0] = expg;
        for (int k = 1; k <= 3; k++) begin
            int c = (expg + k * Q) % N;
            if (weak_sh[c]) begin
                exp_grp[nslot] = c;
                nslot++;
            end
        end
        for (int j = 0; j < 4; j++) begin got_grp[j] = -1; got_ext[j] = -1; end
        @(negedge clk); ref_cmd = 1'b1;
        @(negedge clk); ref_cmd = 1'b0;
        chk({tag, " R3 busy after command"}, int'(busy), 1);
        while (busy && n < 40) begin
            if (n % TRFC == 0 && n / TRFC < 4) begin
                got_grp[n / TRFC] = int'(grp);
                got_ext[n / TRFC] = int'(extra);
            end
            @(negedge clk);
            n++;
        end
        chk({tag, " R6 busy length"}, n, nslot * TRFC);
        chk({tag, " R2 normal group"}, got_grp[0], exp_grp[0]);
        chk({tag, " R5 normal flag"}, got_ext[0], 0);
        for (int j = 1; j < nslot; j++) begin
            chk({tag, " R4 R5 extra group"}, got_grp[j], exp_grp[j]);
            chk({tag, " R5 extra flag"}, got_ext[j], 1);
        end
        chk({tag, " R9 flag low when idle"}, int'(extra), 0);
        expg = (expg + 1) % N;
    endtask

    task automatic t_reset();
        chk("R1 busy at reset", int'(busy), 0);
        chk("R1 err at reset", int'(err), 0);
        chk("R1 extra at reset", int'(extra), 0);
        chk("R1 group at reset", int'(grp), 0);
        run_ref("R1 first command");
    endtask

    task automatic t_two_extra();
        wr_weak(1 + Q, 1'b1);
        wr_weak(1 + 3 * Q, 1'b1);
        run_ref("R4 two candidates");
    endtask

    task automatic t_own_weak();
        wr_weak(2, 1'b1);
        run_ref("R4 own bit ignored");
    endtask

    task automatic t_three_extra();
        wr_weak(3 + Q, 1'b1);
        wr_weak(3 + 2 * Q, 1'b1);
        wr_weak(3 + 3 * Q, 1'b1);
        run_ref("R6 four slots");
    endtask

    task automatic t_rewrite();
        wr_weak(4 + 2 * Q, 1'b1);
        wr_weak(4 + 2 * Q, 1'b0);
        wr_weak(4 + 3 * Q, 1'b0);
        run_ref("R8 cleared bit");
    endtask

    task automatic t_drop();
        int n;
        for (int k = 1; k <= 3; k++) wr_weak((expg + k * Q) % N, 1'b0);
        @(negedge clk); ref_cmd = 1'b1;
        @(negedge clk); ref_cmd = 1'b0;
        n = 0;
        chk("R7 busy before drop", int'(busy), 1);
        @(negedge clk); n++;
        ref_cmd = 1'b1;
        @(negedge clk); n++;
        ref_cmd = 1'b0;
        chk("R7 error pulse", int'(err), 1);
        @(negedge clk); n++;
        chk("R7 error single cycle", int'(err), 0);
        while (busy && n < 40) begin @(negedge clk); n++; end
        chk("R7 length unchanged", n, TRFC);
        repeat (3) @(negedge clk);
        chk("R7 not queued", int'(busy), 0);
        expg = (expg + 1) % N;
        run_ref("R7 counter advanced once");
    endtask

    task automatic t_sweep();
        wr_weak(1, 1'b1);
        wr_weak(9, 1'b1);
        for (int i = 0; i < N + 2; i++) run_ref("R2 sweep and wrap");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_two_extra();
        t_own_weak();
        t_three_extra();
        t_rewrite();
        t_drop();
        t_sweep();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R6 watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule